// File: doc/BRIEF.md
# Per-Hart Load-Reserved / Store-Conditional Reservation Tracker

This block tracks address reservations for a fixed set of hardware threads (harts). Each hart owns a small last-in first-out stack. The stack holds the addresses that the hart's load-reserved operations have claimed. An address is stored at a 16-byte granule, so its four low bits are dropped. Other agents can invalidate a reservation: a snoop names a hart and an address, and it removes that hart's newest reservation when both fall in the same cache block. A store-conditional query asks whether the hart's newest reservation covers the store's granule. The answer comes back one clock later, both as a pass flag and as the code that the core writes to its destination register.

Each hart has a counter of failed store-conditionals. When several events reach the same hart in one cycle, they are applied in a fixed order: snoop, then store-conditional, then load-reserved. The cache, the memory write and the bus protocol are handled elsewhere.

Top module: `rsv_tracker`

## Requirements
- R1: A load-reserved stores its address with bits [3:0] cleared on top of the issuing hart's stack. A later store-conditional from that hart to any address in the same 16-byte granule passes.
- R2: Events for one hart never read or change another hart's stack or counter. A store-conditional to an address that only another hart has reserved fails.
- R3: A snoop aimed at a hart whose stack is empty changes nothing.
- R4: A snoop removes the hart's top entry when the top entry and the snoop address are equal after both drop their block-offset bits (log2 of BLK_BYTES). A snoop compares only the top entry.
- R5: A store-conditional fails when the hart's stack is empty, or when the top entry differs from the store address with bits [3:0] cleared. Older entries are never consulted.
- R6: Each failing store-conditional adds one to that hart's failure count on `fail_cnt_o`. Hart h occupies bits [h*CNT_W +: CNT_W]. A passing store-conditional leaves the count unchanged.
- R7: `sc_pass_o` is 1 for success and 0 for failure. `sc_rd_o` carries the inverse: 0 for success and 1 for failure.
- R8: A passing store-conditional removes the top entry. A failing one leaves the stack unchanged.
- R9: A query with `sc_valid_i` high at a clock edge produces `sc_resp_o` high after that same edge, with the result. No query means no response.
- R10: A load-reserved onto a full stack (DEPTH entries) discards the oldest entry and keeps the rest.
- R11: When events reach the same hart in one cycle, the snoop acts first, the store-conditional then sees the stack the snoop left, and the load-reserved pushes last.
- R12: Reset (`rst_n` low) empties every stack and clears every failure count and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_valid_i | input | 1 | Load-reserved event |
| lr_hart_i | input | HART_W | Hart issuing the load-reserved |
| lr_addr_i | input | ADDR_W | Physical address reserved |
| snp_valid_i | input | 1 | Invalidating snoop event |
| snp_hart_i | input | HART_W | Hart whose stack the snoop checks |
| snp_addr_i | input | ADDR_W | Snooped address |
| sc_valid_i | input | 1 | Store-conditional query |
| sc_hart_i | input | HART_W | Hart issuing the store-conditional |
| sc_addr_i | input | ADDR_W | Store address |
| sc_resp_o | output | 1 | Response valid, one cycle after the query |
| sc_pass_o | output | 1 | 1 = store-conditional succeeded |
| sc_rd_o | output | 1 | Destination-register code, 0 = success |
| fail_cnt_o | output | NUM_HARTS*CNT_W | Per-hart failure counts, hart 0 in the low bits |

## Verification
The bench builds the tracker with three harts, a stack depth of two and 32-byte blocks. With depth two, a third reservation overflows the stack, so the oldest-entry discard is reached after a few events. With 32-byte blocks the snoop mask is wider than the 16-byte granule but different from the default, so one test snoops an address that misses the granule yet hits the block. The three harts make it possible to check isolation while another hart holds reservations at nearby addresses. A single cycle that carries a snoop, a store-conditional and a load-reserved for the same hart pins down the processing order.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    // reservation granule: addresses are kept with this many low bits dropped
    localparam int unsigned GRAN_LSB = 4;
    // destination-register codes for a store-conditional
    localparam logic SC_RD_OK   = 1'b0;
    localparam logic SC_RD_FAIL = 1'b1;
endpackage

// File: rtl/rsv_hart_stack.sv
module rsv_hart_stack
    import rsv_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned BLK_BYTES = 64,
    parameter int unsigned CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_en,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              sc_en,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              lr_en,
    input  logic [ADDR_W-1:0] lr_addr,
    output logic              sc_ok,
    output logic [CNT_W-1:0]  fail_cnt
);
    localparam int unsigned TAG_W  = ADDR_W - GRAN_LSB;
    localparam int unsigned BLK_SH = $clog2(BLK_BYTES) - GRAN_LSB;
    localparam int unsigned CW     = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] ent [DEPTH];
    logic [CW-1:0]    cnt, cnt_mid, cnt_end;
    logic [TAG_W-1:0] top_now, top_mid;
    logic             snp_pop, sc_hit;

    wire [TAG_W-1:0] snp_tag = snp_addr[ADDR_W-1:GRAN_LSB];
    wire [TAG_W-1:0] sc_tag  = sc_addr[ADDR_W-1:GRAN_LSB];
    wire [TAG_W-1:0] lr_tag  = lr_addr[ADDR_W-1:GRAN_LSB];

    // ordered chain: snoop on the current top, then the store-conditional on
    // what the snoop leaves; the load-reserved push is applied in the register
    always_comb begin
        top_now = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt == CW'(i + 1)) top_now = ent[i];
        snp_pop = snp_en && (cnt != '0) &&
                  (top_now[TAG_W-1:BLK_SH] == snp_tag[TAG_W-1:BLK_SH]);
        cnt_mid = cnt - CW'(snp_pop);
        top_mid = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_mid == CW'(i + 1)) top_mid = ent[i];
        sc_hit  = sc_en && (cnt_mid != '0) && (top_mid == sc_tag);
        cnt_end = cnt_mid - CW'(sc_hit);
    end

    assign sc_ok = sc_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (lr_en) begin
            if (cnt_end == CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
                ent[DEPTH-1] <= lr_tag;
                cnt <= cnt_end;
            end else begin
                for (int i = 0; i < DEPTH; i++)
                    if (cnt_end == CW'(i)) ent[i] <= lr_tag;
                cnt <= cnt_end + CW'(1);
            end
        end else begin
            cnt <= cnt_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                fail_cnt <= '0;
        else if (sc_en && !sc_hit) fail_cnt <= fail_cnt + CNT_W'(1);
    end

    // R6: a failed query bumps the count by exactly one
    p_fail_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_en && !sc_ok) |=> (fail_cnt == $past(fail_cnt) + CNT_W'(1)));
    // R6: a passing query leaves the count alone
    p_pass_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_en && sc_ok) |=> $stable(fail_cnt));
    // R8: a lone passing query shrinks the stack by one
    p_pass_pops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_en && sc_ok && !snp_en && !lr_en) |=> (cnt == $past(cnt) - CW'(1)));
    // R3: snooping an empty stack keeps it empty
    p_empty_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_en && cnt == '0 && !lr_en) |=> (cnt == '0));
    // R1: a lone reservation below capacity grows the stack by one
    p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_en && !snp_en && !sc_en && cnt < CW'(DEPTH)) |=> (cnt == $past(cnt) + CW'(1)));
    // R10: a push onto a full stack keeps it full
    p_full_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_en && !snp_en && !sc_en && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));
    // R10: occupancy never exceeds the depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/rsv_sc_resp.sv
module rsv_sc_resp
    import rsv_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sc_valid,
    input  logic [NUM_HARTS-1:0] hart_ok,
    output logic                 resp,
    output logic                 pass,
    output logic                 rd_code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp <= 1'b0;
            pass <= 1'b0;
        end else begin
            resp <= sc_valid;
            pass <= sc_valid && (|hart_ok);
        end
    end

    assign rd_code = pass ? SC_RD_OK : SC_RD_FAIL;

    // R2: at most one hart's stack answers a query
    p_one_hart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hart_ok));
    // R9: every query is answered on the next cycle
    p_resp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> resp);
    // R9: no answer without a query
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !resp);
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned BLK_BYTES = 64,
    parameter int unsigned CNT_W     = 16,
    localparam int unsigned HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lr_valid_i,
    input  logic [HART_W-1:0]          lr_hart_i,
    input  logic [ADDR_W-1:0]          lr_addr_i,
    input  logic                       snp_valid_i,
    input  logic [HART_W-1:0]          snp_hart_i,
    input  logic [ADDR_W-1:0]          snp_addr_i,
    input  logic                       sc_valid_i,
    input  logic [HART_W-1:0]          sc_hart_i,
    input  logic [ADDR_W-1:0]          sc_addr_i,
    output logic                       sc_resp_o,
    output logic                       sc_pass_o,
    output logic                       sc_rd_o,
    output logic [NUM_HARTS*CNT_W-1:0] fail_cnt_o
);
    logic [NUM_HARTS-1:0] hart_ok;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        wire lr_sel  = lr_valid_i  && (lr_hart_i  == HART_W'(h));
        wire snp_sel = snp_valid_i && (snp_hart_i == HART_W'(h));
        wire sc_sel  = sc_valid_i  && (sc_hart_i  == HART_W'(h));

        rsv_hart_stack #(
            .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)
        ) u_stack (
            .clk      (clk),
            .rst_n    (rst_n),
            .snp_en   (snp_sel),
            .snp_addr (snp_addr_i),
            .sc_en    (sc_sel),
            .sc_addr  (sc_addr_i),
            .lr_en    (lr_sel),
            .lr_addr  (lr_addr_i),
            .sc_ok    (hart_ok[h]),
            .fail_cnt (fail_cnt_o[h*CNT_W +: CNT_W])
        );
    end

    rsv_sc_resp #(.NUM_HARTS(NUM_HARTS)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_valid (sc_valid_i),
        .hart_ok  (hart_ok),
        .resp     (sc_resp_o),
        .pass     (sc_pass_o),
        .rd_code  (sc_rd_o)
    );
endmodule

// File: tb/rsv_tracker_tb.sv
`timescale 1ns/1ps
module rsv_tracker_tb;
    localparam int H  = 3;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int HW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lr_v = 1'b0, snp_v = 1'b0, sc_v = 1'b0;
    logic [HW-1:0] lr_h = '0, snp_h = '0, sc_h = '0;
    logic [AW-1:0] lr_a = '0, snp_a = '0, sc_a = '0;
    logic sc_resp, sc_pass, sc_rd;
    logic [H*CW-1:0] fcnt;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rsv_tracker #(.NUM_HARTS(H), .ADDR_W(AW), .DEPTH(2), .BLK_BYTES(32), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lr_valid_i(lr_v), .lr_hart_i(lr_h), .lr_addr_i(lr_a),
        .snp_valid_i(snp_v), .snp_hart_i(snp_h), .snp_addr_i(snp_a),
        .sc_valid_i(sc_v), .sc_hart_i(sc_h), .sc_addr_i(sc_a),
        .sc_resp_o(sc_resp), .sc_pass_o(sc_pass), .sc_rd_o(sc_rd),
        .fail_cnt_o(fcnt)
    );

    // entry: {kind[1:0], hart[1:0], expected pass, address[31:0]}
    // kind 0 = load-reserved, 1 = snoop, 2 = store-conditional
    localparam int NV = 26;
    localparam bit [36:0] VEC [NV] = '{
        {2'd2, 2'd0, 1'b0, 32'h0000_0100},  // R5 empty stack fails
        {2'd0, 2'd0, 1'b0, 32'h0000_1004},  // R1 reserve granule 0x1000
        {2'd2, 2'd0, 1'b1, 32'h0000_100C},  // R1 same granule passes
        {2'd2, 2'd0, 1'b0, 32'h0000_1000},  // R8 popped, now empty
        {2'd0, 2'd1, 1'b0, 32'h0000_2000},
        {2'd2, 2'd0, 1'b0, 32'h0000_2000},  // R2 other hart's reservation
        {2'd2, 2'd1, 1'b0, 32'h0000_2010},  // R5 different granule
        {2'd2, 2'd1, 1'b1, 32'h0000_200F},  // R8 failed query kept the entry
        {2'd0, 2'd2, 1'b0, 32'h0000_3000},
        {2'd0, 2'd2, 1'b0, 32'h0000_3040},
        {2'd1, 2'd2, 1'b0, 32'h0000_3000},  // R4 top is another block
        {2'd2, 2'd2, 1'b1, 32'h0000_3040},  // R4 top survived
        {2'd1, 2'd2, 1'b0, 32'h0000_301C},  // R4 same 32-byte block, pops
        {2'd2, 2'd2, 1'b0, 32'h0000_3000},  // R4 entry gone
        {2'd1, 2'd1, 1'b0, 32'h0000_5000},  // R3 snoop on empty stack
        {2'd0, 2'd1, 1'b0, 32'h0000_6000},
        {2'd0, 2'd1, 1'b0, 32'h0000_6100},
        {2'd0, 2'd1, 1'b0, 32'h0000_6200},  // R10 overflow drops 0x6000
        {2'd2, 2'd1, 1'b1, 32'h0000_6200},
        {2'd2, 2'd1, 1'b1, 32'h0000_6100},
        {2'd2, 2'd1, 1'b0, 32'h0000_6000},  // R10 oldest discarded
        {2'd0, 2'd0, 1'b0, 32'h0000_7000},
        {2'd0, 2'd0, 1'b0, 32'h0000_7100},
        {2'd2, 2'd0, 1'b0, 32'h0000_7000},  // R5 only the top is checked
        {2'd2, 2'd0, 1'b1, 32'h0000_7100},
        {2'd2, 2'd0, 1'b1, 32'h0000_7000}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_ev();
        lr_v = 1'b0; snp_v = 1'b0; sc_v = 1'b0;
    endtask

    // drive at a falling edge, wait one cycle, sample at the next falling edge
    task automatic step();
        @(negedge clk);
        clear_ev();
    endtask

    task automatic chk_cnt(input int h, input int exp, input string req);
        chk(fcnt[h*CW +: CW] == CW'(exp), req, fcnt[h*CW +: CW], exp);
    endtask

    task automatic chk_sc(input bit exp, input string req);
        chk(sc_resp == 1'b1, {req, " resp"}, sc_resp, 1);
        chk(sc_pass == exp, {req, " pass"}, sc_pass, exp);
        chk(sc_rd == !exp, "R7 rd code", sc_rd, !exp);
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(sc_resp == 1'b0, "R12 resp in reset", sc_resp, 0);
        for (int h = 0; h < H; h++) chk_cnt(h, 0, "R12 counter in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] kind;
            kind = VEC[i][36:35];
            case (kind)
                2'd0: begin lr_v = 1'b1;  lr_h = VEC[i][34:33];  lr_a = VEC[i][31:0]; end
                2'd1: begin snp_v = 1'b1; snp_h = VEC[i][34:33]; snp_a = VEC[i][31:0]; end
                default: begin sc_v = 1'b1; sc_h = VEC[i][34:33]; sc_a = VEC[i][31:0]; end
            endcase
            step();
            if (kind == 2'd2) chk_sc(VEC[i][32], $sformatf("R5 vector %0d", i));
            else chk(sc_resp == 1'b0, "R9 no query no response", sc_resp, 0);
        end
        chk_cnt(0, 4, "R6 hart0 failures");
        chk_cnt(1, 2, "R6 hart1 failures");
        chk_cnt(2, 1, "R6 hart2 failures");

        // R11 same-cycle order on hart 2: snoop pops 0x9000, query sees empty, push 0xA000
        lr_v = 1'b1; lr_h = 2'd2; lr_a = 32'h0000_9000;
        step();
        snp_v = 1'b1; snp_h = 2'd2; snp_a = 32'h0000_9010;
        sc_v  = 1'b1; sc_h  = 2'd2; sc_a  = 32'h0000_9000;
        lr_v  = 1'b1; lr_h  = 2'd2; lr_a  = 32'h0000_A000;
        step();
        chk_sc(1'b0, "R11 query after snoop");
        chk_cnt(2, 2, "R11 hart2 failure count");
        sc_v = 1'b1; sc_h = 2'd2; sc_a = 32'h0000_A004;
        step();
        chk_sc(1'b1, "R11 push applied last");
        chk_cnt(0, 4, "R2 hart0 untouched");

        // R12 reset in mid-run empties stacks and clears counters
        lr_v = 1'b1; lr_h = 2'd0; lr_a = 32'h0000_8000;
        step();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int h = 0; h < H; h++) chk_cnt(h, 0, "R12 counters cleared");
        chk(sc_resp == 1'b0, "R12 resp cleared", sc_resp, 0);
        sc_v = 1'b1; sc_h = 2'd0; sc_a = 32'h0000_8000;
        step();
        chk_sc(1'b0, "R12 reservation dropped");
        chk_cnt(0, 1, "R12 count after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule